// File: doc/BRIEF.md
# Printer Port Register Controller

This block is a byte-wide, register-mapped controller for a standard printer port whose printer side is modelled inside the block. A host reaches three registers over a simple single-cycle bus: an output/input data register, a status register and a control register. The control register drives a small handshake model. Writes to it move the busy and acknowledge status bits, and repeated status reads step those bits through a toggle sequence, so a polling driver sees a printer that accepts bytes.

Each rising edge of the control strobe bit, with the port initialised and selected, sends the output byte to a byte-stream port as a one-cycle valid pulse. The stream has no ready signal and so cannot apply back-pressure. The sink must take the byte in the cycle where valid is high, because the block neither holds nor repeats it. A level interrupt is raised from control-register activity and is cleared when the host reads status.

Read data is combinational from the current state and the address presented. Every register update, including the side effects of a status read, takes effect on the clock edge that ends the access cycle.

Top module: `prn_port_ctrl`

## Requirements
- R1: Only the low three address bits are decoded. Offset 0 is data, offset 1 is status and offset 2 is control, whatever the upper address bits hold.
- R2: A read of offsets 3 to 7 returns 0xFF. A write to offsets 1 and 3 to 7 changes no register.
- R3: A control write stores the written byte with bits 7:6 forced to 1, and a control read returns the stored value. Control bit positions are: 5 direction (1 = input), 4 interrupt enable, 3 select, 2 init (active when 0 resets the printer), 1 auto-linefeed, 0 strobe.
- R4: A control write with init = 0 loads status with 0xD8. Status bit positions are: 7 not-busy, 6 acknowledge, 5 paper-out, 4 online, 3 no-error, 0 timeout.
- R5: A control write with init = 1, select = 1 and strobe = 1 clears status bit 7. If the stored strobe was 0 before that write, the output data byte appears on tx_data with tx_valid high in the cycle after the write.
- R6: A control write with init = 1, select = 1 and strobe = 0 sets interrupt-pending when the interrupt-enable bit stored before the write is 1.
- R7: A status read returns the current status and clears interrupt-pending.
- R8: During a status read with status bit 7 = 0 and stored strobe = 0, the read clears acknowledge if it is set. If acknowledge is clear, the read sets both acknowledge and bit 7.
- R9: A data read returns the input latch when the stored direction bit is 1, and the output latch written at offset 0 otherwise.
- R10: After reset, both data latches are 0xFF, status is 0xD9, control is 0xCC, interrupt-pending is 0 and tx_valid is 0.
- R11: The irq output is the interrupt-pending state as a level, one cycle after the access that changes it.
- R12: tx_valid is high for exactly one cycle per emitted byte, and the block has no ready input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Bus access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register address; low three bits decoded |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the presented address (combinational) |
| irq | output | 1 | Level interrupt, equals interrupt-pending |
| tx_valid | output | 1 | One-cycle pulse: tx_data carries an emitted byte |
| tx_data | output | 8 | Emitted output byte |

## Verification
The bench builds the block with ADDR_W = 5, so that two address bits lie above the decoded field. Random accesses with those bits set therefore check that every offset aliases correctly and that unmapped offsets stay inert. Directed sequences walk the strobe, interrupt and acknowledge toggle paths from reset, and random control bytes are biased toward init and select set so the handshake states are reached often.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam int BYTE_W = 8;
  localparam int DEC_W  = 3;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam logic [DEC_W-1:0] OFS_DATA = 3'd0;
  localparam logic [DEC_W-1:0] OFS_STAT = 3'd1;
  localparam logic [DEC_W-1:0] OFS_CTRL = 3'd2;

  // status bit positions
  localparam int ST_NBUSY = 7;
  localparam int ST_ACK   = 6;
  // control bit positions
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_STB  = 0;

  localparam byte_t RST_DATA    = 8'hFF;
  localparam byte_t RST_STATUS  = 8'hD9;
  localparam byte_t RST_CTRL    = 8'hCC;
  localparam byte_t INIT_STATUS = 8'hD8;
  localparam byte_t CTRL_FORCE  = 8'hC0;
  localparam byte_t UNMAPPED_RD = 8'hFF;

  typedef struct packed {
    logic data_wr;
    logic stat_rd;
    logic ctrl_wr;
  } acc_t;
endpackage

// File: rtl/prn_reg_decode.sv
module prn_reg_decode
  import prn_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [DEC_W-1:0]  ofs,
  output acc_t              acc
);
  assign ofs = acc_addr[DEC_W-1:0];

  generate
    if (ADDR_W > DEC_W) begin : g_upper
      logic unused_upper;
      assign unused_upper = ^acc_addr[ADDR_W-1:DEC_W];
    end
  endgenerate

  always_comb begin
    acc         = '0;
    acc.data_wr = acc_en &&  acc_wr && (ofs == OFS_DATA);
    acc.stat_rd = acc_en && !acc_wr && (ofs == OFS_STAT);
    acc.ctrl_wr = acc_en &&  acc_wr && (ofs == OFS_CTRL);
  end
endmodule

// File: rtl/prn_handshake.sv
module prn_handshake
  import prn_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  acc_t  acc,
  input  byte_t wdata,
  output byte_t status_q,
  output byte_t ctrl_q,
  output logic  pend_q,
  output logic  emit
);
  byte_t ctrl_new;
  logic  ready_sel;

  always_comb begin
    ctrl_new  = wdata | CTRL_FORCE;
    ready_sel = ctrl_new[CT_INIT] && ctrl_new[CT_SEL];
    emit      = acc.ctrl_wr && ready_sel && ctrl_new[CT_STB] && !ctrl_q[CT_STB];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= RST_STATUS;
      ctrl_q   <= RST_CTRL;
      pend_q   <= 1'b0;
    end else begin
      if (acc.ctrl_wr) begin
        ctrl_q <= ctrl_new;
        if (!ctrl_new[CT_INIT]) begin
          status_q <= INIT_STATUS;
        end else if (ctrl_new[CT_SEL]) begin
          if (ctrl_new[CT_STB]) begin
            status_q[ST_NBUSY] <= 1'b0;
          end else if (ctrl_q[CT_IEN]) begin
            pend_q <= 1'b1;
          end
        end
      end
      if (acc.stat_rd) begin
        pend_q <= 1'b0;
        if (!status_q[ST_NBUSY] && !ctrl_q[CT_STB]) begin
          if (status_q[ST_ACK]) begin
            status_q[ST_ACK] <= 1'b0;
          end else begin
            status_q[ST_ACK]   <= 1'b1;
            status_q[ST_NBUSY] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/prn_data_path.sv
module prn_data_path
  import prn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  acc_t             acc,
  input  byte_t            wdata,
  input  logic [DEC_W-1:0] ofs,
  input  byte_t            status_q,
  input  byte_t            ctrl_q,
  input  logic             emit,
  output byte_t            rdata,
  output logic             tx_valid,
  output byte_t            tx_data
);
  byte_t out_q;
  byte_t in_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q    <= RST_DATA;
      in_q     <= RST_DATA;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (acc.data_wr) out_q <= wdata;
      tx_valid <= emit;
      if (emit) tx_data <= out_q;
    end
  end

  always_comb begin
    case (ofs)
      OFS_DATA: rdata = ctrl_q[CT_DIR] ? in_q : out_q;
      OFS_STAT: rdata = status_q;
      OFS_CTRL: rdata = ctrl_q;
      default:  rdata = UNMAPPED_RD;
    endcase
  end
endmodule

// File: rtl/prn_port_ctrl.sv
module prn_port_ctrl
  import prn_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  output logic              irq,
  output logic              tx_valid,
  output logic [7:0]        tx_data
);
  logic [DEC_W-1:0] ofs;
  acc_t             acc;
  byte_t            status_q;
  byte_t            ctrl_q;
  logic             pend_q;
  logic             emit;

  prn_reg_decode #(.ADDR_W(ADDR_W)) i_dec (
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .ofs(ofs), .acc(acc)
  );

  prn_handshake i_hs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wdata(acc_wdata),
    .status_q(status_q), .ctrl_q(ctrl_q), .pend_q(pend_q), .emit(emit)
  );

  prn_data_path i_dp (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wdata(acc_wdata), .ofs(ofs),
    .status_q(status_q), .ctrl_q(ctrl_q), .emit(emit),
    .rdata(acc_rdata), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  assign irq = pend_q;
endmodule

// File: rtl/prn_port_ctrl_chk.sv
module prn_port_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_en,
  input logic       acc_wr,
  input logic [2:0] ofs,
  input logic [7:0] wdata,
  input logic [7:0] status_q,
  input logic [7:0] ctrl_q,
  input logic       irq,
  input logic       tx_valid
);
  assert_init_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && ofs == 3'd2 && !wdata[2]) |=> (status_q == 8'hD8));

  assert_strobe_emit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && ofs == 3'd2 && wdata[2] && wdata[3] && wdata[0] && !ctrl_q[0])
    |=> tx_valid);

  assert_stat_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && ofs == 3'd1) |=> !irq);

  assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && (ofs == 3'd1 || ofs > 3'd2))
    |=> ($stable(status_q) && $stable(ctrl_q)));

  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(acc_en && acc_wr && ofs == 3'd2));

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);
endmodule

bind prn_port_ctrl prn_port_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .ofs(ofs),
  .wdata(acc_wdata), .status_q(status_q), .ctrl_q(ctrl_q), .irq(irq),
  .tx_valid(tx_valid)
);

// File: tb/test_prn_port_ctrl.sv
module test_prn_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_en = 1'b0;
  logic              acc_wr = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [7:0]        acc_wdata = '0;
  logic [7:0]        acc_rdata;
  logic              irq;
  logic              tx_valid;
  logic [7:0]        tx_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model state
  logic [7:0] m_out, m_in, m_stat, m_ctrl;
  logic       m_pend;

  prn_port_ctrl #(.ADDR_W(ADDR_W)) i_prn_port_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] o);
    case (o)
      3'd0:    return m_ctrl[5] ? m_in : m_out;
      3'd1:    return m_stat;
      3'd2:    return m_ctrl;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic model_reset();
    m_out = 8'hFF; m_in = 8'hFF; m_stat = 8'hD9; m_ctrl = 8'hCC; m_pend = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [ADDR_W-1:0] addr,
                        input logic [7:0] wd, input string tag);
    logic [2:0] o;
    logic [7:0] nv;
    logic       em;
    logic [7:0] em_byte;
    o = addr[2:0];
    em = 1'b0;
    em_byte = m_out;
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_addr = addr; acc_wdata = wd;
    #1;
    if (!wr) chk(tag, acc_rdata, exp_read(o));
    if (wr && o == 3'd0) m_out = wd;
    if (wr && o == 3'd2) begin
      nv = wd | 8'hC0;
      if (!nv[2]) m_stat = 8'hD8;
      else if (nv[3]) begin
        if (nv[0]) begin
          m_stat[7] = 1'b0;
          if (!m_ctrl[0]) em = 1'b1;
        end else if (m_ctrl[4]) m_pend = 1'b1;
      end
      m_ctrl = nv;
    end
    if (!wr && o == 3'd1) begin
      m_pend = 1'b0;
      if (!m_stat[7] && !m_ctrl[0]) begin
        if (m_stat[6]) m_stat[6] = 1'b0;
        else begin m_stat[6] = 1'b1; m_stat[7] = 1'b1; end
      end
    end
    @(posedge clk);
    #1;
    acc_en = 1'b0; acc_wr = 1'b0;
    chk({tag, " R5/R12 tx_valid"}, {7'd0, tx_valid}, {7'd0, em});
    if (em) chk("R5 tx_data", tx_data, em_byte);
    chk("R11 irq", {7'd0, irq}, {7'd0, m_pend});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 tx_valid after reset", {7'd0, tx_valid}, 8'd0);
    chk("R10 irq after reset", {7'd0, irq}, 8'd0);

    // reset values and unmapped offsets
    access(1'b0, 5'd0, 8'h00, "R10 data");
    access(1'b0, 5'd1, 8'h00, "R10 status");
    access(1'b0, 5'd2, 8'h00, "R10 control");
    for (int i = 3; i < 8; i++) access(1'b0, ADDR_W'(i), 8'h00, "R2 unmapped read");
    access(1'b0, 5'h19, 8'h00, "R1 aliased status");
    access(1'b0, 5'h0A, 8'h00, "R1 aliased control");

    // data latch mux
    access(1'b1, 5'd0, 8'h5A, "R9 write");
    access(1'b0, 5'd0, 8'h00, "R9 output latch");
    access(1'b1, 5'd2, 8'h2C, "R3 dir in");
    access(1'b0, 5'd2, 8'h00, "R3 control readback");
    access(1'b0, 5'd0, 8'h00, "R9 input latch");

    // interrupt and strobe
    access(1'b1, 5'd2, 8'h1C, "R6 enable stored");
    access(1'b1, 5'd2, 8'h1C, "R6 pending set");
    access(1'b1, 5'd2, 8'h1D, "R5 strobe rise");
    access(1'b1, 5'd2, 8'h1D, "R5 strobe held");
    access(1'b0, 5'd1, 8'h00, "R7 status clears");
    access(1'b1, 5'd2, 8'h1C, "R6 pending again");
    access(1'b0, 5'd1, 8'h00, "R8 ack clear");
    access(1'b0, 5'd1, 8'h00, "R8 ack busy set");
    access(1'b0, 5'd1, 8'h00, "R8 settled");

    // init and ignored writes
    access(1'b1, 5'd2, 8'h08, "R4 init");
    access(1'b0, 5'd1, 8'h00, "R4 status");
    access(1'b1, 5'd1, 8'h00, "R2 status write");
    access(1'b1, 5'd7, 8'h00, "R2 offset7 write");
    access(1'b0, 5'd1, 8'h00, "R2 status kept");
    access(1'b0, 5'd2, 8'h00, "R2 control kept");

    // constrained random
    for (int n = 0; n < 800; n++) begin
      int unsigned sel;
      logic [ADDR_W-1:0] a;
      logic [7:0] d;
      sel = $urandom % 100;
      a = ADDR_W'($urandom);
      d = 8'($urandom);
      if (sel < 40) begin
        if (($urandom % 4) != 0) d = d | 8'h0C;
        access(1'b1, {a[ADDR_W-1:3], 3'd2}, d, "R3 rnd ctrl write");
        access(1'b0, {a[ADDR_W-1:3], 3'd2}, 8'h00, "R3 rnd ctrl read");
      end else if (sel < 62) access(1'b0, {a[ADDR_W-1:3], 3'd1}, 8'h00, "R7 rnd status read");
      else if (sel < 75) access(1'b1, {a[ADDR_W-1:3], 3'd0}, d, "R9 rnd data write");
      else if (sel < 85) access(1'b0, {a[ADDR_W-1:3], 3'd0}, 8'h00, "R9 rnd data read");
      else if (a[2:0] > 3'd2 || a[2:0] == 3'd1) access(1'b1, a, d, "R2 rnd ignored write");
      else access(1'b0, {a[ADDR_W-1:3], 3'd5}, 8'h00, "R2 rnd unmapped read");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule